// File: doc/BRIEF.md
# ULPI PHY Register Bank

This block is the register file and interrupt generator that a USB link controller sees inside a ULPI transceiver. It holds read-only identity bytes, the function control, interface control and OTG control registers, the rising and falling interrupt enables, and a scratch byte. Every writable register sits at three consecutive addresses. The first takes a plain write. The second ORs the write data into the register. The third clears the bits that are set in the write data. All three addresses read back the current value.

Five live status inputs are synchronized: host disconnect, VBUS valid, session valid, session end and ID. Edges on these inputs are qualified by the two enable masks and recorded in sticky latch bits. A read of the latch returns those bits and clears them. The interrupt output stays high while any latch bit is set. A simple request/write/address/data port takes the place of the ULPI bus. The function, interface and OTG control values drive the rest of the transceiver.

Top module: `ulpi_reg_bank`

## Requirements
- R1: Addresses 00h..03h read the constants VENDOR_ID[7:0], VENDOR_ID[15:8], PRODUCT_ID[7:0] and PRODUCT_ID[15:8]. Writes to these addresses change nothing.
- R2: Each writable register with base address B takes a plain write at B, an OR with the write data at B+1, and a clear of the bits set in the write data at B+2. All three addresses read the register value. The update is visible one cycle after the access.
- R3: The writable registers, with their bases and power-on values, are: function control 04h = 41h (bit 7 reserved, reads 0); interface control 07h = 00h (bit 4 reserved, reads 0); OTG control 0Ah = 06h; rising enable 0Dh = 1Fh; falling enable 10h = 1Fh (enable bits 7:5 reserved, read 0); scratch 16h = 00h. Outputs func_ctrl_o, if_ctrl_o and otg_ctrl_o show the first three registers.
- R4: Address 13h returns the synchronized status in bits 4:0, ordered host disconnect 0, VBUS valid 1, session valid 2, session end 3, ID 4. The value is visible two clock edges after sts_i changes.
- R5: A latch bit sets when its synchronized status rises with the matching rising-enable bit set, or falls with the matching falling-enable bit set. The bit is set three edges after the sts_i change. An edge whose enable bit is clear sets nothing.
- R6: A read of 14h returns the latch and clears it. If a qualified edge arrives in the same cycle as the read, its bit stays set.
- R7: irq_o is high exactly while any latch bit is set.
- R8: Address 15h returns {6'b0, linestate_i}.
- R9: When function control bit 5 (Reset) becomes 1, every writable register returns to its power-on value on the next edge, which also clears bit 5.
- R10: Addresses 19h..3Fh read zero and ignore writes. Writes to 13h, 14h and 15h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from addr_i) |
| sts_i | input | 5 | Raw status inputs, asynchronous |
| linestate_i | input | 2 | Current line state |
| func_ctrl_o | output | 8 | Function control register |
| if_ctrl_o | output | 8 | Interface control register |
| otg_ctrl_o | output | 8 | OTG control register |
| irq_o | output | 1 | Interrupt, high while any latch bit is set |

## Verification
The assertions check on every cycle the behaviours that follow from the access port alone. These are the identity and debug read data, zero data on unmapped reads, and the plain OTG write taking effect. They also check that a latch read returns nonzero data exactly when irq_o is high, and that the Reset bit self-clears and restores the power-on values. Edge qualification, the synchronizer latency, and the case of an edge colliding with a latch read all depend on timed sequences of status changes. Only the bench scenarios can show them, together with the set and clear address aliases.

// File: rtl/ulpi_reg_pkg.sv
package ulpi_reg_pkg;
  localparam int NUM_STS = 5;
  localparam int NUM_RW  = 6;
  localparam int DW      = 8;
  localparam int AW      = 6;

  typedef enum int {RW_FUNC = 0, RW_IFC = 1, RW_OTG = 2,
                    RW_RISE = 3, RW_FALL = 4, RW_SCR = 5} rw_idx_e;

  // index 0 in the low slice
  localparam logic [NUM_RW-1:0][AW-1:0] RW_BASE =
    {6'h16, 6'h10, 6'h0D, 6'h0A, 6'h07, 6'h04};
  localparam logic [NUM_RW-1:0][DW-1:0] RW_RST  =
    {8'h00, 8'h1F, 8'h1F, 8'h06, 8'h00, 8'h41};
  localparam logic [NUM_RW-1:0][DW-1:0] RW_MASK =
    {8'hFF, 8'h1F, 8'h1F, 8'hFF, 8'hEF, 8'h7F};

  localparam logic [AW-1:0] ADDR_STATUS = 6'h13;
  localparam logic [AW-1:0] ADDR_LATCH  = 6'h14;
  localparam logic [AW-1:0] ADDR_DEBUG  = 6'h15;
  localparam logic [AW-1:0] ADDR_LAST   = 6'h18;
  localparam int FUNC_RESET_BIT = 5;
endpackage

// File: rtl/ulpi_rw_reg.sv
module ulpi_rw_reg #(
  parameter int          DW   = 8,
  parameter logic [DW-1:0] RST  = '0,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          wr_i,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= RST;
    else if (soft_rst_i) q_o <= RST;
    else if (wr_i)       q_o <= wdata_i & MASK;
    else if (set_i)      q_o <= q_o | (wdata_i & MASK);
    else if (clr_i)      q_o <= q_o & ~wdata_i;
  end
endmodule

// File: rtl/ulpi_sts_edge.sv
module ulpi_sts_edge #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sts_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= sts_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign rise_o = sync_o & ~prev_q;
  assign fall_o = ~sync_o & prev_q;
endmodule

// File: rtl/ulpi_irq_latch.sv
module ulpi_irq_latch #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] hit;
  assign hit = (rise_i & rise_en_i) | (fall_i & fall_en_i);

  // a new edge beats the clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_o <= '0;
    else if (rd_clr_i) lat_o <= hit;
    else               lat_o <= lat_o | hit;
  end
endmodule

// File: rtl/ulpi_reg_bank.sv
module ulpi_reg_bank
  import ulpi_reg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'hA5C3,
  parameter logic [15:0] PRODUCT_ID  = 16'h0E71,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NUM_STS-1:0] sts_i,
  input  logic [1:0]         linestate_i,
  output logic [DW-1:0]      func_ctrl_o,
  output logic [DW-1:0]      if_ctrl_o,
  output logic [DW-1:0]      otg_ctrl_o,
  output logic               irq_o
);
  logic [NUM_RW-1:0][DW-1:0] rw_q;
  logic [NUM_STS-1:0]        sts_sync, sts_rise, sts_fall, lat;
  logic                      soft_rst, wr_acc, rd_acc;

  assign wr_acc   = req_i & we_i;
  assign rd_acc   = req_i & ~we_i;
  // R9: Reset bit held for one cycle, then everything reloads
  assign soft_rst = rw_q[RW_FUNC][FUNC_RESET_BIT];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    ulpi_rw_reg #(.DW(DW), .RST(RW_RST[g]), .MASK(RW_MASK[g])) u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .wr_i       (wr_acc && addr_i == RW_BASE[g]),
      .set_i      (wr_acc && addr_i == RW_BASE[g] + 6'd1),
      .clr_i      (wr_acc && addr_i == RW_BASE[g] + 6'd2),
      .wdata_i    (wdata_i),
      .q_o        (rw_q[g])
    );
  end

  ulpi_sts_edge #(.W(NUM_STS), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sts_i  (sts_i),
    .sync_o (sts_sync),
    .rise_o (sts_rise),
    .fall_o (sts_fall)
  );

  ulpi_irq_latch #(.W(NUM_STS)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (sts_rise),
    .fall_i    (sts_fall),
    .rise_en_i (rw_q[RW_RISE][NUM_STS-1:0]),
    .fall_en_i (rw_q[RW_FALL][NUM_STS-1:0]),
    .rd_clr_i  (rd_acc && addr_i == ADDR_LATCH),
    .lat_o     (lat)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      6'h00: rdata_o = VENDOR_ID[7:0];
      6'h01: rdata_o = VENDOR_ID[15:8];
      6'h02: rdata_o = PRODUCT_ID[7:0];
      6'h03: rdata_o = PRODUCT_ID[15:8];
      ADDR_STATUS: rdata_o = {{(DW-NUM_STS){1'b0}}, sts_sync};
      ADDR_LATCH:  rdata_o = {{(DW-NUM_STS){1'b0}}, lat};
      ADDR_DEBUG:  rdata_o = {{(DW-2){1'b0}}, linestate_i};
      default: begin
        for (int i = 0; i < NUM_RW; i++) begin
          if (addr_i == RW_BASE[i] || addr_i == RW_BASE[i] + 6'd1 ||
              addr_i == RW_BASE[i] + 6'd2)
            rdata_o = rw_q[i];
        end
      end
    endcase
  end

  assign func_ctrl_o = rw_q[RW_FUNC];
  assign if_ctrl_o   = rw_q[RW_IFC];
  assign otg_ctrl_o  = rw_q[RW_OTG];
  assign irq_o       = |lat;   // R7
endmodule

// File: rtl/ulpi_reg_bank_chk.sv
module ulpi_reg_bank_chk
  import ulpi_reg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hA5C3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [1:0]    linestate_i,
  input logic [DW-1:0] func_ctrl_o,
  input logic [DW-1:0] if_ctrl_o,
  input logic [DW-1:0] otg_ctrl_o,
  input logic          irq_o
);
  p_id_lo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 6'h00) |-> rdata_o == VENDOR_ID[7:0]);

  p_otg_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 6'h0A && !func_ctrl_o[FUNC_RESET_BIT])
      |=> otg_ctrl_o == $past(wdata_i));

  p_irq_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_LATCH) |-> ((rdata_o != '0) == irq_o));

  p_debug_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_DEBUG) |-> rdata_o == {6'b0, linestate_i});

  p_selfclear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_ctrl_o[FUNC_RESET_BIT] |=> !func_ctrl_o[FUNC_RESET_BIT]);

  p_soft_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_ctrl_o[FUNC_RESET_BIT] |=> (func_ctrl_o == RW_RST[RW_FUNC] &&
      if_ctrl_o == RW_RST[RW_IFC] && otg_ctrl_o == RW_RST[RW_OTG]));

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i > ADDR_LAST) |-> rdata_o == '0);
endmodule

bind ulpi_reg_bank ulpi_reg_bank_chk #(.VENDOR_ID(VENDOR_ID)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .linestate_i (linestate_i),
  .func_ctrl_o (func_ctrl_o),
  .if_ctrl_o   (if_ctrl_o),
  .otg_ctrl_o  (otg_ctrl_o),
  .irq_o       (irq_o)
);

// File: tb/ulpi_reg_bank_tb.sv
`timescale 1ns/1ps
module ulpi_reg_bank_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, func_ctrl_o, if_ctrl_o, otg_ctrl_o;
  logic [4:0] sts_i = '0;
  logic [1:0] linestate_i = 2'b10;
  logic       irq_o;
  int checks = 0, failures = 0;
  logic [7:0] rd_val;

  always #4 clk_i = ~clk_i;

  ulpi_reg_bank u_dut (.*);

  // {we, addr, wdata, expected, req}; writes carry no check
  // R1 ids, R2 set/clear aliases, R3 resets/masks, R8 debug, R10 ignored
  localparam int NV = 39;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0,6'h00,8'h00,8'hC3,4'd1}, {1'b0,6'h01,8'h00,8'hA5,4'd1},
    {1'b0,6'h02,8'h00,8'h71,4'd1}, {1'b0,6'h03,8'h00,8'h0E,4'd1},
    {1'b1,6'h00,8'hFF,8'h00,4'd1}, {1'b0,6'h00,8'h00,8'hC3,4'd1},
    {1'b0,6'h04,8'h00,8'h41,4'd3}, {1'b0,6'h07,8'h00,8'h00,4'd3},
    {1'b0,6'h0A,8'h00,8'h06,4'd3}, {1'b0,6'h0D,8'h00,8'h1F,4'd3},
    {1'b0,6'h10,8'h00,8'h1F,4'd3}, {1'b0,6'h16,8'h00,8'h00,4'd3},
    {1'b1,6'h16,8'h5A,8'h00,4'd2}, {1'b0,6'h16,8'h00,8'h5A,4'd2},
    {1'b1,6'h17,8'h81,8'h00,4'd2}, {1'b0,6'h18,8'h00,8'hDB,4'd2},
    {1'b1,6'h18,8'h0A,8'h00,4'd2}, {1'b0,6'h16,8'h00,8'hD1,4'd2},
    {1'b1,6'h04,8'hC2,8'h00,4'd3}, {1'b0,6'h06,8'h00,8'h42,4'd3},
    {1'b1,6'h0E,8'hE0,8'h00,4'd3}, {1'b0,6'h0D,8'h00,8'h1F,4'd3},
    {1'b1,6'h0F,8'h03,8'h00,4'd2}, {1'b0,6'h0E,8'h00,8'h1C,4'd2},
    {1'b1,6'h0D,8'h1F,8'h00,4'd2}, {1'b0,6'h15,8'h00,8'h02,4'd8},
    {1'b1,6'h15,8'hFF,8'h00,4'd10},{1'b0,6'h15,8'h00,8'h02,4'd10},
    {1'b1,6'h14,8'hFF,8'h00,4'd10},{1'b0,6'h14,8'h00,8'h00,4'd10},
    {1'b1,6'h3F,8'hFF,8'h00,4'd10},{1'b0,6'h3F,8'h00,8'h00,4'd10},
    {1'b0,6'h19,8'h00,8'h00,4'd10},{1'b1,6'h0B,8'h80,8'h00,4'd2},
    {1'b0,6'h0C,8'h00,8'h86,4'd2}, {1'b1,6'h08,8'h10,8'h00,4'd3},
    {1'b0,6'h07,8'h00,8'h00,4'd3}, {1'b1,6'h04,8'h41,8'h00,4'd3},
    {1'b1,6'h0A,8'h06,8'h00,4'd3}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    req_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R3 / R7: power-on state at the ports
    check("R3 func", func_ctrl_o, 8'h41);
    check("R3 otg", otg_ctrl_o, 8'h06);
    check("R3 ifc", if_ctrl_o, 8'h00);
    check("R7 irq idle", {7'b0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) wr(VEC[i][25:20], VEC[i][19:12]);
      else begin
        rd(VEC[i][25:20], rd_val);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd_val, VEC[i][11:4]);
      end
    end

    // R4: synchronized status after two edges
    @(negedge clk_i) sts_i = 5'b10101;
    @(posedge clk_i); @(posedge clk_i);
    rd(6'h13, rd_val); check("R4 status", rd_val, 8'h15);
    // R5 / R7: rising edges latched
    @(negedge clk_i) check("R7 irq set", {7'b0, irq_o}, 8'h01);
    rd(6'h14, rd_val); check("R5 rise latch", rd_val, 8'h15);
    // R6: cleared by read
    @(negedge clk_i) check("R6 irq cleared", {7'b0, irq_o}, 8'h00);
    rd(6'h14, rd_val); check("R6 latch empty", rd_val, 8'h00);

    // R5: falling mask picks only bit 2
    wr(6'h10, 8'h04);
    @(negedge clk_i) sts_i = 5'b00000;
    repeat (4) @(posedge clk_i);
    rd(6'h14, rd_val); check("R5 fall mask", rd_val, 8'h04);

    // R5: disabled rising edge sets nothing
    wr(6'h0D, 8'h00);
    @(negedge clk_i) sts_i = 5'b00001;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i) check("R5 disabled", {7'b0, irq_o}, 8'h00);

    // R6: edge in the same cycle as a latch read survives
    wr(6'h0D, 8'h1F);
    @(negedge clk_i) sts_i = 5'b00011;
    @(posedge clk_i); @(posedge clk_i);
    rd(6'h14, rd_val); check("R6 read during edge", rd_val, 8'h00);
    @(negedge clk_i) check("R6 irq kept", {7'b0, irq_o}, 8'h01);
    rd(6'h14, rd_val); check("R6 kept bit", rd_val, 8'h02);

    // R9: soft reset
    wr(6'h16, 8'h33);
    wr(6'h0A, 8'h00);
    wr(6'h05, 8'h20);
    @(negedge clk_i) check("R9 reset bit", func_ctrl_o, 8'h61);
    @(negedge clk_i);
    check("R9 func restored", func_ctrl_o, 8'h41);
    check("R9 otg restored", otg_ctrl_o, 8'h06);
    rd(6'h16, rd_val); check("R9 scratch restored", rd_val, 8'h00);
    rd(6'h10, rd_val); check("R9 fall en restored", rd_val, 8'h1F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule